// File: doc/BRIEF.md
# ATA Task-File Register Bank

This block is the host side of a two-device ATA channel's register file. A host performs byte writes and reads through a 3-bit register offset, plus separate writes to a device-control byte. Each write to the task file lands in the copies held for both devices. Reads return the copy that belongs to the currently selected device. Each address byte keeps a one-deep history of its earlier value. Setting the high-order-byte bit in the device-control byte returns that history on reads, which is how a host reads back the upper half of a 48-bit address.

The block also sequences the soft reset. Clearing the reset bit in the device-control byte, after it was set, puts both devices into BUSY at once. After a fixed, parameterised delay, both devices load their reset signature. The block drives a level interrupt: a completion pulse from the device engine raises it, and a status read or a command write lowers it. A write to the command offset is passed on as a one-cycle strobe with its code. The command engine and the data path sit outside this block.

Register offsets: 0 = data, 1 = features (write) / error (read), 2 = sector count, 3 = sector number, 4 = cylinder low, 5 = cylinder high, 6 = device/head, 7 = command (write) / status (read). Device-control bits: 7 = high-order readback (HOB), 2 = soft reset (SRST), 1 = interrupt block (nIEN).

Top module: `ata_taskfile_bank`

## Requirements
- R1: After hardware reset:
  - the irq output is 0 and cmd_stb is 0;
  - every device reads sector count 0x01, sector number 0x01, device/head 0xA0 and error 0x01;
  - a disk device reads status 0x50 and a packet device (default: device 1) reads status 0x00.
- R2: A write to an offset from 1 to 5 moves that register's current value into its high-order copy and then stores the new byte. The write reaches both devices.
- R3: While HOB (control bit 7) is 1, reads of offsets 2 to 5 return the high-order copies. Offsets 1, 6 and 7 read the same as with HOB at 0.
- R4: A task-file write to offset 1, 6 or 7 clears HOB. A write to offsets 2 to 5 leaves HOB unchanged.
- R5: A device/head write stores the byte with bits 7 and 5 forced to 1, in both devices. Bit 4 of that byte picks which device's copy is returned on reads.
- R6: A write to offset 7 does two things:
  - it raises cmd_stb for exactly the one cycle after the write edge, with cmd_code equal to the written byte;
  - it lowers irq.
- R7: A control write that takes SRST (bit 2) from 1 to 0 sets BUSY (status bit 7) in both devices from the next cycle on. A write that sets SRST, or leaves it set, does not change status.
- R8: The soft reset completes exactly RST_DLY clocks after the falling SRST write edge. BUSY reads as set up to that edge. The reset then loads the signature of R1, and also:
  - the high-order copies read 0;
  - the selected device is unchanged.
- R9: A done_pulse raises irq when nIEN (control bit 1) is 0 and does nothing when nIEN is 1. Setting nIEN does not lower an irq that is already raised. If a raise and a clear fall in the same cycle, the raise wins.
- R10: A read of offset 7 (status) with tf_rd high lowers irq.
- R11: Reads of offset 0 return 0xFF. Offset 1 reads the error register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| tf_wr | input | 1 | Task-file write strobe |
| tf_rd | input | 1 | Task-file read strobe (read side effects) |
| tf_ofs | input | 3 | Task-file register offset |
| tf_wdata | input | 8 | Task-file write byte |
| tf_rdata | output | 8 | Read byte for tf_ofs from the selected device |
| ctl_wr | input | 1 | Device-control write strobe |
| ctl_wdata | input | 8 | Device-control write byte |
| done_pulse | input | 1 | Command completion pulse from the device engine |
| cmd_stb | output | 1 | One-cycle command issue strobe |
| cmd_code | output | 8 | Command byte carried with cmd_stb |
| dev_sel | output | 1 | Currently selected device |
| irq | output | 1 | Level interrupt request |

## Verification
The embedded assertions check several properties on every cycle:
- the history shift on a count write, and the forced bits of a device/head write;
- HOB clearing after the three clearing offsets, and the strobe timing of a command write;
- BUSY in both devices after a falling SRST write, and the reset counter's load, bound and decrement;
- that irq never rises without an unmasked completion in the cycle before, and that it falls after a clear that has no competing raise.

Only the bench scenarios can show:
- the read-side views: HOB readback against current values, and per-device status selected by bit 4;
- the exact completion edge of the delayed reset, with the full signature and cleared history afterwards;
- that rising or steady SRST writes, and masked completions, leave the outputs alone.

// File: rtl/atatf_pkg.sv
`timescale 1ns/1ps
package atatf_pkg;
    localparam int TF_W    = 8;
    localparam int NUM_DEV = 2;
    localparam int SEL_W   = $clog2(NUM_DEV);
    localparam int PAIR_LO = 1;
    localparam int PAIR_HI = 5;

    // register offsets (host-visible map)
    localparam logic [2:0] OFS_DATA  = 3'd0;
    localparam logic [2:0] OFS_FEAT  = 3'd1;
    localparam logic [2:0] OFS_COUNT = 3'd2;
    localparam logic [2:0] OFS_NUM   = 3'd3;
    localparam logic [2:0] OFS_CYLLO = 3'd4;
    localparam logic [2:0] OFS_CYLHI = 3'd5;
    localparam logic [2:0] OFS_DEVHD = 3'd6;
    localparam logic [2:0] OFS_CMD   = 3'd7;

    // control and device/head bit positions
    localparam int CTL_HOB   = 7;
    localparam int CTL_SRST  = 2;
    localparam int CTL_NIEN  = 1;
    localparam int DEVHD_SEL = 4;

    localparam logic [TF_W-1:0] DEVHD_FIXED  = 8'hA0;
    localparam logic [TF_W-1:0] ST_BUSY      = 8'h80;
    localparam logic [TF_W-1:0] ST_IDLE_DISK = 8'h50;
    localparam logic [TF_W-1:0] ST_IDLE_PKT  = 8'h00;
    localparam logic [TF_W-1:0] ERR_SIG      = 8'h01;
    localparam logic [TF_W-1:0] SIG_COUNT    = 8'h01;
    localparam logic [TF_W-1:0] SIG_NUM      = 8'h01;
    localparam logic [TF_W-1:0] DATA_IDLE    = 8'hFF;

    typedef struct packed {
        logic [TF_W-1:0] cur;
        logic [TF_W-1:0] prev;
    } byte_pair_t;

    typedef struct packed {
        byte_pair_t [PAIR_HI:PAIR_LO] pairs;
        logic [TF_W-1:0]              devhd;
        logic [TF_W-1:0]              error;
        logic [TF_W-1:0]              status;
    } tf_state_t;
endpackage

// File: rtl/atatf_dev_regs.sv
`timescale 1ns/1ps
module atatf_dev_regs
    import atatf_pkg::*;
#(
    parameter bit PACKET_DEV = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [2:0]      wr_ofs,
    input  logic [TF_W-1:0] wdata,
    input  logic            busy_set,
    input  logic            reset_apply,
    output tf_state_t       state_o
);
    localparam int IDX_COUNT = int'(OFS_COUNT);
    localparam int IDX_NUM   = int'(OFS_NUM);

    tf_state_t state_d, state_q;

    function automatic tf_state_t fresh_state();
        tf_state_t s;
        s = '0;
        s.pairs[IDX_COUNT].cur = SIG_COUNT;
        s.pairs[IDX_NUM].cur   = SIG_NUM;
        s.devhd  = DEVHD_FIXED;
        s.error  = ERR_SIG;
        s.status = PACKET_DEV ? ST_IDLE_PKT : ST_IDLE_DISK;
        return s;
    endfunction

    always_comb begin
        state_d = state_q;
        if (reset_apply) begin
            state_d = fresh_state();
        end else if (wr_en) begin
            for (int i = PAIR_LO; i <= PAIR_HI; i++) begin
                if (wr_ofs == 3'(i)) begin
                    state_d.pairs[i].prev = state_q.pairs[i].cur;
                    state_d.pairs[i].cur  = wdata;
                end
            end
            if (wr_ofs == OFS_DEVHD) begin
                state_d.devhd = wdata | DEVHD_FIXED;
            end
        end
        if (busy_set) begin
            state_d.status = state_d.status | ST_BUSY;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= fresh_state();
        else        state_q <= state_d;
    end

    assign state_o = state_q;

    // R2: count write shifts old value into the high-order copy
    a_r2_count_shift: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_ofs == OFS_COUNT && !reset_apply |=>
            state_q.pairs[IDX_COUNT].prev == $past(state_q.pairs[IDX_COUNT].cur) &&
            state_q.pairs[IDX_COUNT].cur  == $past(wdata));

    // R5: device/head keeps bits 7 and 5 set
    a_r5_devhd_forced: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_ofs == OFS_DEVHD && !reset_apply |=>
            state_q.devhd == ($past(wdata) | DEVHD_FIXED));

    // R8: completion loads the signature
    a_r8_signature: assert property (@(posedge clk) disable iff (!rst_n)
        reset_apply |=> state_q.pairs[IDX_COUNT].cur == SIG_COUNT &&
                        state_q.pairs[IDX_NUM].cur == SIG_NUM &&
                        state_q.devhd == DEVHD_FIXED);
endmodule

// File: rtl/atatf_srst_seq.sv
`timescale 1ns/1ps
module atatf_srst_seq #(
    parameter int RST_DLY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic srst_fall,
    output logic busy_set,
    output logic reset_apply
);
    localparam int CW = $clog2(RST_DLY + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } seq_state_t;

    seq_state_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (srst_fall) begin
            seq_d.cnt = CW'(RST_DLY);
        end else if (seq_q.cnt != '0) begin
            seq_d.cnt = seq_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy_set    = srst_fall;
    assign reset_apply = (seq_q.cnt == CW'(1));

    // R7: a falling SRST write arms the full delay
    a_r7_arm: assert property (@(posedge clk) disable iff (!rst_n)
        srst_fall |=> seq_q.cnt == CW'(RST_DLY));

    // R8: counter never exceeds the delay
    a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.cnt <= CW'(RST_DLY));

    // R8: one step per clock while pending
    a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.cnt != '0 && !srst_fall |=> seq_q.cnt == $past(seq_q.cnt) - CW'(1));
endmodule

// File: rtl/atatf_irq_ctrl.sv
`timescale 1ns/1ps
module atatf_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic done_pulse,
    input  logic nien,
    input  logic clr,
    output logic irq_o
);
    typedef struct packed {
        logic irq;
    } irq_state_t;

    irq_state_t irq_d, irq_q;
    logic       raise;

    assign raise = done_pulse && !nien;

    always_comb begin
        irq_d = irq_q;
        if (raise)    irq_d.irq = 1'b1;
        else if (clr) irq_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq_o = irq_q.irq;

    // R9: irq only rises after an unmasked completion
    a_r9_masked_raise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(done_pulse && !nien));

    // R10: a clear with no competing raise lowers irq
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !(done_pulse && !nien) |=> !irq_o);
endmodule

// File: rtl/ata_taskfile_bank.sv
`timescale 1ns/1ps
module ata_taskfile_bank
    import atatf_pkg::*;
#(
    parameter int               RST_DLY     = 8,
    parameter logic [NUM_DEV-1:0] PACKET_MASK = 2'b10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tf_wr,
    input  logic       tf_rd,
    input  logic [2:0] tf_ofs,
    input  logic [7:0] tf_wdata,
    output logic [7:0] tf_rdata,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    input  logic       done_pulse,
    output logic       cmd_stb,
    output logic [7:0] cmd_code,
    output logic       dev_sel,
    output logic       irq
);
    typedef struct packed {
        logic             hob;
        logic             srst;
        logic             nien;
        logic [SEL_W-1:0] sel;
        logic             cmd_stb;
        logic [TF_W-1:0]  cmd_code;
    } top_state_t;

    top_state_t top_d, top_q;
    tf_state_t  dev_state [NUM_DEV];
    tf_state_t  act;

    logic srst_fall, busy_set, reset_apply, irq_clr;
    logic cmd_wr, hob_clear_wr;

    assign cmd_wr       = tf_wr && tf_ofs == OFS_CMD;
    assign hob_clear_wr = tf_wr && (tf_ofs == OFS_FEAT || tf_ofs == OFS_DEVHD || tf_ofs == OFS_CMD);
    assign srst_fall    = ctl_wr && top_q.srst && !ctl_wdata[CTL_SRST];
    assign irq_clr      = cmd_wr || (tf_rd && tf_ofs == OFS_CMD);

    always_comb begin
        top_d         = top_q;
        top_d.cmd_stb = cmd_wr;
        if (cmd_wr) top_d.cmd_code = tf_wdata;
        if (ctl_wr) begin
            top_d.hob  = ctl_wdata[CTL_HOB];
            top_d.srst = ctl_wdata[CTL_SRST];
            top_d.nien = ctl_wdata[CTL_NIEN];
        end else if (hob_clear_wr) begin
            top_d.hob = 1'b0;
        end
        if (tf_wr && tf_ofs == OFS_DEVHD) begin
            top_d.sel = tf_wdata[DEVHD_SEL +: SEL_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    genvar g;
    generate
        for (g = 0; g < NUM_DEV; g++) begin : g_dev
            atatf_dev_regs #(.PACKET_DEV(PACKET_MASK[g])) u_dev (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_en      (tf_wr),
                .wr_ofs     (tf_ofs),
                .wdata      (tf_wdata),
                .busy_set   (busy_set),
                .reset_apply(reset_apply),
                .state_o    (dev_state[g])
            );
        end
    endgenerate

    atatf_srst_seq #(.RST_DLY(RST_DLY)) u_srst (
        .clk        (clk),
        .rst_n      (rst_n),
        .srst_fall  (srst_fall),
        .busy_set   (busy_set),
        .reset_apply(reset_apply)
    );

    atatf_irq_ctrl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_pulse(done_pulse),
        .nien      (top_q.nien),
        .clr       (irq_clr),
        .irq_o     (irq)
    );

    // read mux over the selected device
    always_comb begin
        act      = dev_state[top_q.sel];
        tf_rdata = DATA_IDLE;
        case (tf_ofs)
            OFS_DATA:  tf_rdata = DATA_IDLE;
            OFS_FEAT:  tf_rdata = act.error;
            OFS_DEVHD: tf_rdata = act.devhd;
            OFS_CMD:   tf_rdata = act.status;
            default: begin
                for (int i = PAIR_LO + 1; i <= PAIR_HI; i++) begin
                    if (tf_ofs == 3'(i)) begin
                        tf_rdata = top_q.hob ? act.pairs[i].prev : act.pairs[i].cur;
                    end
                end
            end
        endcase
    end

    logic unused_bits;
    assign unused_bits = ^{ctl_wdata[6:3], ctl_wdata[0], tf_wdata[7:5], tf_wdata[3:0],
                           dev_state[0].pairs[PAIR_LO], dev_state[1].pairs[PAIR_LO]};

    assign cmd_stb  = top_q.cmd_stb;
    assign cmd_code = top_q.cmd_code;
    assign dev_sel  = top_q.sel;

    // R4: features, device/head and command writes clear HOB
    a_r4_hob_clear: assert property (@(posedge clk) disable iff (!rst_n)
        hob_clear_wr && !ctl_wr |=> !top_q.hob);

    // R6: command write gives a strobe with its code
    a_r6_cmd_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> cmd_stb && cmd_code == $past(tf_wdata));

    // R6: no strobe without a command write
    a_r6_cmd_single: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> !cmd_stb);

    // R7: falling SRST makes both devices busy
    a_r7_busy_both: assert property (@(posedge clk) disable iff (!rst_n)
        srst_fall |=> dev_state[0].status[7] && dev_state[1].status[7]);
endmodule

// File: tb/ata_taskfile_bank_bench.sv
`timescale 1ns/1ps
module ata_taskfile_bank_bench;
    localparam int DLY = 6;

    logic       clk = 1'b0;
    logic       rst_n, tf_wr, tf_rd, ctl_wr, done_pulse;
    logic [2:0] tf_ofs;
    logic [7:0] tf_wdata, ctl_wdata, tf_rdata, cmd_code;
    logic       cmd_stb, dev_sel, irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    typedef struct {
        logic [2:0] ofs;
        logic [7:0] exp;
        string      req;
    } rd_item_t;
    rd_item_t sb_q[$];

    always #2.5 clk = ~clk;

    ata_taskfile_bank #(.RST_DLY(DLY), .PACKET_MASK(2'b10)) u_ata_taskfile_bank (
        .clk(clk), .rst_n(rst_n), .tf_wr(tf_wr), .tf_rd(tf_rd), .tf_ofs(tf_ofs),
        .tf_wdata(tf_wdata), .tf_rdata(tf_rdata), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .done_pulse(done_pulse), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
        .dev_sel(dev_sel), .irq(irq)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // monitor: pops expected read items and compares as reads occur
    always @(negedge clk) begin
        if (rst_n && tf_rd) begin
            if (sb_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL scoreboard: unexpected read actual 0x%02h expected none", tf_rdata);
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                check({it.req, " ofs"}, {5'd0, tf_ofs}, {5'd0, it.ofs});
                check(it.req, tf_rdata, it.exp);
            end
        end
    end

    task automatic tf_write(logic [2:0] ofs, logic [7:0] val);
        @(posedge clk); #1;
        tf_wr = 1'b1; tf_ofs = ofs; tf_wdata = val;
        @(posedge clk); #1;
        tf_wr = 1'b0;
    endtask

    task automatic ctl_write(logic [7:0] val);
        @(posedge clk); #1;
        ctl_wr = 1'b1; ctl_wdata = val;
        @(posedge clk); #1;
        ctl_wr = 1'b0;
    endtask

    task automatic rd_exp(logic [2:0] ofs, logic [7:0] exp, string req);
        rd_item_t it;
        @(posedge clk); #1;
        tf_rd = 1'b1; tf_ofs = ofs;
        it.ofs = ofs; it.exp = exp; it.req = req;
        sb_q.push_back(it);
        @(posedge clk); #1;
        tf_rd = 1'b0;
    endtask

    task automatic pulse_done();
        @(posedge clk); #1;
        done_pulse = 1'b1;
        @(posedge clk); #1;
        done_pulse = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        rst_n = 1'b0; tf_wr = 1'b0; tf_rd = 1'b0; ctl_wr = 1'b0; done_pulse = 1'b0;
        tf_ofs = '0; tf_wdata = '0; ctl_wdata = '0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 cmd_stb", {7'd0, cmd_stb}, 8'h00);
        rd_exp(3'd7, 8'h50, "R1 status dev0");
        rd_exp(3'd2, 8'h01, "R1 count");
        rd_exp(3'd3, 8'h01, "R1 number");
        rd_exp(3'd6, 8'hA0, "R1 devhead");
        rd_exp(3'd1, 8'h01, "R1 R11 error");
        rd_exp(3'd0, 8'hFF, "R11 data idle");
        tf_write(3'd6, 8'h10);
        check("R5 dev_sel", {7'd0, dev_sel}, 8'h01);
        rd_exp(3'd6, 8'hB0, "R5 devhead forced bits");
        rd_exp(3'd7, 8'h00, "R1 status packet dev1");
        tf_write(3'd6, 8'h00);

        // R2: history shift, both devices
        tf_write(3'd2, 8'h11);
        tf_write(3'd2, 8'h22);
        rd_exp(3'd2, 8'h22, "R2 count current");
        tf_write(3'd4, 8'hA1);
        tf_write(3'd4, 8'hA2);
        rd_exp(3'd4, 8'hA2, "R2 cyllo current");
        tf_write(3'd6, 8'h10);
        rd_exp(3'd2, 8'h22, "R2 count in dev1");
        tf_write(3'd6, 8'h00);

        // R3: HOB readback
        ctl_write(8'h80);
        rd_exp(3'd2, 8'h11, "R3 count high copy");
        rd_exp(3'd4, 8'hA1, "R3 cyllo high copy");
        rd_exp(3'd6, 8'hA0, "R3 devhead unaffected");
        rd_exp(3'd1, 8'h01, "R3 error unaffected");

        // R4: which writes clear HOB
        tf_write(3'd3, 8'h77);
        rd_exp(3'd2, 8'h11, "R4 number write keeps HOB");
        tf_write(3'd1, 8'h5A);
        rd_exp(3'd2, 8'h22, "R4 features write clears HOB");
        ctl_write(8'h80);
        tf_write(3'd6, 8'h00);
        rd_exp(3'd2, 8'h22, "R4 devhead write clears HOB");
        ctl_write(8'h80);
        tf_write(3'd7, 8'hEC);
        check("R6 cmd_stb high", {7'd0, cmd_stb}, 8'h01);
        check("R6 cmd_code", cmd_code, 8'hEC);
        @(posedge clk); #1;
        check("R6 cmd_stb one cycle", {7'd0, cmd_stb}, 8'h00);
        rd_exp(3'd2, 8'h22, "R4 command write clears HOB");

        // R9 / R10: interrupt
        pulse_done();
        check("R9 irq raised", {7'd0, irq}, 8'h01);
        rd_exp(3'd7, 8'h50, "R10 status read");
        check("R10 irq cleared by status read", {7'd0, irq}, 8'h00);
        ctl_write(8'h02);
        pulse_done();
        check("R9 nIEN blocks raise", {7'd0, irq}, 8'h00);
        ctl_write(8'h00);
        pulse_done();
        check("R9 irq raised again", {7'd0, irq}, 8'h01);
        ctl_write(8'h02);
        check("R9 nIEN does not lower", {7'd0, irq}, 8'h01);
        tf_write(3'd7, 8'h00);
        check("R6 command write lowers irq", {7'd0, irq}, 8'h00);
        ctl_write(8'h00);
        begin
            rd_item_t it;
            @(posedge clk); #1;
            done_pulse = 1'b1; tf_rd = 1'b1; tf_ofs = 3'd7;
            it.ofs = 3'd7; it.exp = 8'h50; it.req = "R10 status read with raise";
            sb_q.push_back(it);
            @(posedge clk); #1;
            done_pulse = 1'b0; tf_rd = 1'b0;
        end
        check("R9 raise wins over clear", {7'd0, irq}, 8'h01);
        rd_exp(3'd7, 8'h50, "R10 status read");

        // R7: rising / steady SRST does nothing
        ctl_write(8'h04);
        rd_exp(3'd7, 8'h50, "R7 rising SRST no busy");
        ctl_write(8'h04);
        rd_exp(3'd7, 8'h50, "R7 steady SRST no busy");

        // R7 / R8: falling SRST, watched on packet device 1
        tf_write(3'd2, 8'h33);
        tf_write(3'd4, 8'h44);
        tf_write(3'd6, 8'h1F);
        ctl_write(8'h00);
        repeat (DLY - 2) @(posedge clk);
        rd_exp(3'd7, 8'h80, "R7 R8 busy on last pending cycle");
        rd_exp(3'd7, 8'h00, "R8 packet status after reset");
        rd_exp(3'd6, 8'hA0, "R8 devhead signature");
        rd_exp(3'd2, 8'h01, "R8 count signature");
        rd_exp(3'd3, 8'h01, "R8 number signature");
        rd_exp(3'd4, 8'h00, "R8 cyllo cleared");
        rd_exp(3'd1, 8'h01, "R8 error signature");
        check("R8 selection kept", {7'd0, dev_sel}, 8'h01);
        ctl_write(8'h80);
        rd_exp(3'd2, 8'h00, "R8 high copy cleared");
        ctl_write(8'h00);
        tf_write(3'd6, 8'h00);
        rd_exp(3'd7, 8'h50, "R8 dev0 status after reset");

        // R7: busy on device 0 right after the falling edge
        ctl_write(8'h04);
        ctl_write(8'h00);
        rd_exp(3'd7, 8'hD0, "R7 dev0 busy");
        repeat (DLY) @(posedge clk);
        rd_exp(3'd7, 8'h50, "R8 dev0 ready after delay");

        repeat (3) @(posedge clk);
        if (sb_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
        end
        report();
    end
endmodule